// File: doc/BRIEF.md
# SPI-Side Control and Power Sequencer for a Serial UART

This block sits between an SPI slave port and the bit engines of a serial UART. Every transfer is a 16-bit full-duplex exchange. While the host shifts a command in on MOSI, the block shifts a status-and-data word out on MISO. So a transfer that writes also reads, and no transfer is write-only. The command takes effect on the rising edge of chip select. An incomplete frame has no effect.

The block holds the configuration bits:
- a shutdown request;
- an interrupt mask for the transmit-empty flag;
- a two-stop-bit select.

It also holds:
- the transmit holding byte and its parity bit;
- the RTS output;
- the combined receiver-activity / framing-error flag.

It pops the receive FIFO when a data transfer has read a valid byte.

A four-state power sequencer (RUN, DRAIN, OFF, WAKE) defers software shutdown. Shutdown waits until chip select has risen, the transmit holding buffer has emptied and the transmitter reports idle. Only then does it stop the oscillator and clear the holding data, the flags and the FIFO. A hardware shutdown input reaches OFF at once. Leaving shutdown restarts the oscillator and holds the bit engines off for a parameterised startup time.

The sequencer's transitions are:

| Transition | Condition |
|---|---|
| RUN→DRAIN | shutdown request set |
| DRAIN→RUN | request cleared |
| DRAIN→OFF | buffer empty and transmitter idle |
| any state→OFF | hardware shutdown |
| OFF→WAKE | no hardware shutdown and request clear |
| WAKE→RUN | startup count expired |

Top module: `spi_uart_ctrl`

## Requirements
- R1: A frame is 16 bits, MSB first, sampled on SCLK rising edges while CS is low. The frame is acted on at CS rising only if exactly 16 bits arrived; otherwise it has no effect. Bits [15:14] give the command:
  - 11: write configuration. Bit 13 is the shutdown request, bit 12 the transmit-empty interrupt mask and bit 11 the two-stop select (`tx_two_stop`).
  - 01: read configuration.
  - 10: write data. Bit 10 holds transmission back, bit 9 is RTS, bit 8 parity and bits [7:0] data.
  - 00: read data.
- R2: Every transfer returns a word on MISO, MSB first, captured when CS falls.
  - Bits 15 and 14 are always R (receive data ready = `rxq_valid` while the engines run) and T (transmit buffer empty).
  - A configuration command returns the shutdown read-back in bit 13, the mask in bit 12, the stop select in bit 11, the activity/error flag in bit 10 and CTS in bit 9. Bits [8:0] are 0.
  - A data command returns 0 in bits [13:11], the activity/error flag in bit 10 and CTS in bit 9. Bit 8 is the receive parity and bits [7:0] the receive data; both are 0 when R is 0.
- R3: A shutdown request takes effect only after CS rises. `osc_en` stays high until T is 1 and `tx_idle` is 1. Clearing the request before then returns to normal operation with no oscillator drop.
- R4: Entering shutdown has these effects:
  - T is cleared to 0.
  - The activity/error flag and the transmit holding data and parity are cleared.
  - `engine_run` drops.
  - `rxq_clear` is held high.
  - R reads 0 for as long as shutdown lasts.
- R5: Every complete write-data frame updates `rts_out` in every power state. CTS is read live in every state. Power transitions never change `rts_out`.
- R6: The shutdown read-back bit is 0 while a software shutdown is draining, even once T is 1 and the transmitter is still busy. It reads 1 once the oscillator has stopped.
- R7: While `hw_shdn` is high, the shutdown read-back reads 1 immediately and `osc_en` is low from the next cycle, whatever the T flag. After release with the request bit 0, the block wakes.
- R8: `irq` is high exactly when the mask bit is 1 and T is 1.
- R9: After reset the following hold:
  - the configuration bits, the activity/error flag and RTS are 0;
  - T is 1;
  - `osc_en` and `engine_run` are 1;
  - `irq` is 0.
- R10: Writing the configuration with the request bit 0 while shut down raises `osc_en` after CS rises. `engine_run` then rises after exactly STARTUP_CYC cycles of `osc_en` high, and T becomes 1 at that point.
- R11: The activity/error flag behaves as follows:
  - While running, `rx_frame_err` sets it and `rx_frame_ok` clears it.
  - While shut down, `rx_line_edge` sets it.
  - A configuration write clears it in any state.
  - A read of data never clears it.
- R12: A data command (bit 14 = 0) whose transfer began with R = 1 pulses `rxq_pop` for exactly one cycle at CS rising. Any other transfer does not pop.
- R13: A write-data frame with bit 10 = 0 in RUN loads the holding byte and parity and clears T. With bit 10 = 1, or outside RUN, only RTS changes. A `tx_take` pulse sets T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; SPI lines are oversampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Command bit stream from the host |
| spi_miso | output | 1 | Response bit stream to the host |
| hw_shdn | input | 1 | Hardware shutdown request, synchronous to clk |
| cts_in | input | 1 | Clear-to-send line level |
| rts_out | output | 1 | Request-to-send line level |
| irq | output | 1 | Interrupt request |
| osc_en | output | 1 | Oscillator / baud clock enable |
| engine_run | output | 1 | Enables the transmit and receive engines |
| tx_hold_valid | output | 1 | Holding byte waiting for the transmitter |
| tx_hold_data | output | 8 | Transmit holding byte |
| tx_hold_par | output | 1 | Transmit holding parity bit |
| tx_two_stop | output | 1 | Send two stop bits |
| tx_take | input | 1 | Transmitter has taken the holding byte |
| tx_idle | input | 1 | Transmitter shift register is idle |
| rxq_valid | input | 1 | Receive FIFO not empty |
| rxq_data | input | 8 | Receive FIFO head byte |
| rxq_par | input | 1 | Receive FIFO head parity bit |
| rxq_pop | output | 1 | Pop the receive FIFO head |
| rxq_clear | output | 1 | Flush the receive FIFO |
| rx_frame_err | input | 1 | Receiver saw a framing error |
| rx_frame_ok | input | 1 | Receiver saw a well-framed character |
| rx_line_edge | input | 1 | Transition seen on the receive line |

## Verification
The bench aims at four corner cases of shutdown.

The first is a drain where T becomes 1 while the transmitter is still busy. A sequencer that ignored `tx_idle` would stop the oscillator one character early, and its read-back would report shutdown too soon.

The second is a request withdrawn mid-drain. Here a design that latched the request would power down anyway.

The third is RTS and the activity flag while shut down. A design that gated writes by power state would lose RTS updates or line-edge wakeups.

The fourth is exact startup length and frames cut short. An off-by-one counter, or a frame decoder that acted on eight bits, would show up as a wrong wake length or a moved RTS. Randomized read-data and write-data transfers with random FIFO contents check the response layout and that each pop matches a ready byte.

// File: rtl/ucs_pkg.sv
package ucs_pkg;

    localparam int FRAME_W = 16;

    // Command-word bit positions
    localparam int B_SD  = 13;
    localparam int B_TM  = 12;
    localparam int B_ST  = 11;
    localparam int B_TE  = 10;
    localparam int B_RTS = 9;
    localparam int B_PAR = 8;

    typedef enum logic [1:0] {
        CMD_RD_DATA = 2'b00,
        CMD_RD_CFG  = 2'b01,
        CMD_WR_DATA = 2'b10,
        CMD_WR_CFG  = 2'b11
    } cmd_t;

    typedef enum logic [1:0] {
        PWR_RUN   = 2'd0,
        PWR_DRAIN = 2'd1,
        PWR_OFF   = 2'd2,
        PWR_WAKE  = 2'd3
    } pwr_state_t;

endpackage

// File: rtl/ucs_spi_frame.sv
module ucs_spi_frame
    import ucs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               cs_n,
    input  logic               mosi,
    input  logic [FRAME_W-1:0] cfg_word,
    input  logic [FRAME_W-1:0] data_word,
    output logic               miso,
    output logic               frame_start,
    output logic               frame_done,
    output logic [FRAME_W-1:0] frame_word
);

    localparam int CW = $clog2(FRAME_W + 2);
    localparam int IW = $clog2(FRAME_W);
    localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_W);
    localparam logic [CW-1:0] CNT_SAT  = CW'(FRAME_W + 1);

    logic [SYNC_STAGES-1:0] sclk_q, cs_q, mosi_q;
    logic                   sclk_d, cs_d;
    logic                   sclk_s, cs_s, mosi_s;
    logic                   cs_fall, cs_rise, sclk_rise;
    logic [CW-1:0]          cnt;
    logic                   cfg_sel;
    logic [FRAME_W-1:0]     sh, snap_cfg, snap_data, sel_word;
    logic [IW-1:0]          bit_idx;

    assign sclk_s = sclk_q[SYNC_STAGES-1];
    assign cs_s   = cs_q[SYNC_STAGES-1];
    assign mosi_s = mosi_q[SYNC_STAGES-1];

    assign cs_fall   = cs_d && !cs_s;
    assign cs_rise   = !cs_d && cs_s;
    assign sclk_rise = !sclk_d && sclk_s && !cs_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_q <= {sclk_q[SYNC_STAGES-2:0], sclk};
            cs_q   <= {cs_q[SYNC_STAGES-2:0], cs_n};
            mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi};
            sclk_d <= sclk_s;
            cs_d   <= cs_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            cfg_sel   <= 1'b0;
            sh        <= '0;
            snap_cfg  <= '0;
            snap_data <= '0;
        end else if (cs_fall) begin
            cnt       <= '0;
            cfg_sel   <= 1'b0;
            snap_cfg  <= cfg_word;
            snap_data <= data_word;
        end else if (sclk_rise) begin
            sh <= {sh[FRAME_W-2:0], mosi_s};
            if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
            if (cnt == CW'(1)) cfg_sel <= mosi_s;
        end
    end

    // Upper two response bits are common; the rest follow the command type
    always_comb begin
        sel_word = (cfg_sel && cnt >= CW'(2)) ? snap_cfg : snap_data;
        bit_idx  = IW'(FRAME_W - 1) - cnt[IW-1:0];
        miso     = (!cs_s && cnt < CNT_FULL) ? sel_word[bit_idx] : 1'b0;
    end

    assign frame_start = cs_fall;
    assign frame_done  = cs_rise && (cnt == CNT_FULL);
    assign frame_word  = sh;

endmodule

// File: rtl/ucs_pwr_seq.sv
module ucs_pwr_seq
    import ucs_pkg::*;
#(
    parameter int STARTUP_CYC = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_shdn,
    input  logic       sd_req,
    input  logic       tx_empty,
    input  logic       tx_idle,
    output pwr_state_t state,
    output logic       enter_off,
    output logic       wake_done
);

    localparam int CW = $clog2(STARTUP_CYC + 1);
    localparam logic [CW-1:0] WAKE_LAST = CW'(STARTUP_CYC - 1);

    pwr_state_t    state_q, state_nx;
    logic [CW-1:0] wake_cnt;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            PWR_RUN: begin
                if (hw_shdn)     state_nx = PWR_OFF;
                else if (sd_req) state_nx = PWR_DRAIN;
            end
            PWR_DRAIN: begin
                if (hw_shdn)                  state_nx = PWR_OFF;
                else if (!sd_req)             state_nx = PWR_RUN;
                else if (tx_empty && tx_idle) state_nx = PWR_OFF;
            end
            PWR_OFF: begin
                if (!hw_shdn && !sd_req) state_nx = PWR_WAKE;
            end
            PWR_WAKE: begin
                if (hw_shdn)                    state_nx = PWR_OFF;
                else if (wake_cnt == WAKE_LAST) state_nx = PWR_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= PWR_RUN;
            wake_cnt <= '0;
        end else begin
            state_q  <= state_nx;
            wake_cnt <= (state_q == PWR_WAKE) ? wake_cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        state     = state_q;
        enter_off = (state_nx == PWR_OFF) && (state_q != PWR_OFF);
        wake_done = (state_q == PWR_WAKE) && (state_nx == PWR_RUN);
    end

endmodule

// File: rtl/spi_uart_ctrl.sv
module spi_uart_ctrl
    import ucs_pkg::*;
#(
    parameter int STARTUP_CYC = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sclk,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    output logic       spi_miso,
    input  logic       hw_shdn,
    input  logic       cts_in,
    output logic       rts_out,
    output logic       irq,
    output logic       osc_en,
    output logic       engine_run,
    output logic       tx_hold_valid,
    output logic [7:0] tx_hold_data,
    output logic       tx_hold_par,
    output logic       tx_two_stop,
    input  logic       tx_take,
    input  logic       tx_idle,
    input  logic       rxq_valid,
    input  logic [7:0] rxq_data,
    input  logic       rxq_par,
    output logic       rxq_pop,
    output logic       rxq_clear,
    input  logic       rx_frame_err,
    input  logic       rx_frame_ok,
    input  logic       rx_line_edge
);

    logic [FRAME_W-1:0] cfg_word, data_word, frame_word;
    logic               frame_start, frame_done;
    pwr_state_t         pstate;
    logic               enter_off, wake_done;

    logic cfg_sd, cfg_tm, cfg_st;
    logic t_flag, fe_q, rts_q, r_snap;
    logic [7:0] hold_d;
    logic       hold_p;

    cmd_t cmd;
    logic wr_cfg, wr_data, data_cmd, load_tx;
    logic running, r_now, sd_rb;

    ucs_spi_frame #(.SYNC_STAGES(SYNC_STAGES)) u_spi (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk        (spi_sclk),
        .cs_n        (spi_cs_n),
        .mosi        (spi_mosi),
        .cfg_word    (cfg_word),
        .data_word   (data_word),
        .miso        (spi_miso),
        .frame_start (frame_start),
        .frame_done  (frame_done),
        .frame_word  (frame_word)
    );

    ucs_pwr_seq #(.STARTUP_CYC(STARTUP_CYC)) u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_shdn   (hw_shdn),
        .sd_req    (cfg_sd),
        .tx_empty  (t_flag),
        .tx_idle   (tx_idle),
        .state     (pstate),
        .enter_off (enter_off),
        .wake_done (wake_done)
    );

    assign cmd      = cmd_t'(frame_word[FRAME_W-1:FRAME_W-2]);
    assign wr_cfg   = frame_done && (cmd == CMD_WR_CFG);
    assign wr_data  = frame_done && (cmd == CMD_WR_DATA);
    assign data_cmd = frame_done && !frame_word[FRAME_W-2];
    assign running  = (pstate == PWR_RUN) || (pstate == PWR_DRAIN);
    assign load_tx  = wr_data && !frame_word[B_TE] && (pstate == PWR_RUN);
    assign r_now    = rxq_valid && running;
    assign sd_rb    = (pstate == PWR_OFF) || hw_shdn;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_sd <= 1'b0;
            cfg_tm <= 1'b0;
            cfg_st <= 1'b0;
            rts_q  <= 1'b0;
            r_snap <= 1'b0;
        end else begin
            if (wr_cfg) begin
                cfg_sd <= frame_word[B_SD];
                cfg_tm <= frame_word[B_TM];
                cfg_st <= frame_word[B_ST];
            end
            if (wr_data)     rts_q  <= frame_word[B_RTS];
            if (frame_start) r_snap <= r_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_flag <= 1'b1;
            hold_d <= '0;
            hold_p <= 1'b0;
        end else if (enter_off) begin
            t_flag <= 1'b0;
            hold_d <= '0;
            hold_p <= 1'b0;
        end else if (wake_done) begin
            t_flag <= 1'b1;
        end else if (load_tx) begin
            t_flag <= 1'b0;
            hold_d <= frame_word[7:0];
            hold_p <= frame_word[B_PAR];
        end else if (tx_take && running) begin
            t_flag <= 1'b1;
        end
    end

    // Activity / framing-error flag: meaning depends on power state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fe_q <= 1'b0;
        end else if (enter_off || wr_cfg) begin
            fe_q <= 1'b0;
        end else if (pstate == PWR_OFF) begin
            if (rx_line_edge) fe_q <= 1'b1;
        end else if (running) begin
            if (rx_frame_err)     fe_q <= 1'b1;
            else if (rx_frame_ok) fe_q <= 1'b0;
        end
    end

    assign cfg_word  = {r_now, t_flag, sd_rb, cfg_tm, cfg_st, fe_q, cts_in, 9'd0};
    assign data_word = {r_now, t_flag, 3'd0, fe_q, cts_in,
                        r_now ? rxq_par : 1'b0, r_now ? rxq_data : 8'd0};

    assign rts_out       = rts_q;
    assign irq           = cfg_tm && t_flag;
    assign osc_en        = (pstate != PWR_OFF);
    assign engine_run    = running;
    assign tx_hold_valid = !t_flag && running;
    assign tx_hold_data  = hold_d;
    assign tx_hold_par   = hold_p;
    assign tx_two_stop   = cfg_st;
    assign rxq_pop       = data_cmd && r_snap && running;
    assign rxq_clear     = (pstate == PWR_OFF);

endmodule

// File: rtl/ucs_chk.sv
module ucs_chk #(
    parameter int STARTUP_CYC = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       osc_en,
    input logic       engine_run,
    input logic       hw_shdn,
    input logic       tx_idle,
    input logic       tx_hold_valid,
    input logic [7:0] tx_hold_data,
    input logic       rxq_clear,
    input logic       rxq_pop,
    input logic       irq,
    input logic       rts_out,
    input logic       frame_done
);

    localparam int OW = $clog2(STARTUP_CYC + 2);
    localparam logic [OW-1:0] ON_SAT = OW'(STARTUP_CYC + 1);

    logic [OW-1:0] on_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              on_cnt <= '0;
        else if (!osc_en)        on_cnt <= '0;
        else if (on_cnt != ON_SAT) on_cnt <= on_cnt + 1'b1;
    end

    a_r3_osc_drop_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en) |-> ($past(hw_shdn) || ($past(tx_idle) && !$past(tx_hold_valid))));

    a_r4_off_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (rxq_clear && tx_hold_data == 8'd0 && !tx_hold_valid && !engine_run));

    a_r5_rts_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rts_out) |-> $past(frame_done));

    a_r7_hw_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        hw_shdn |=> !osc_en);

    a_r8_irq_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!tx_hold_valid && osc_en));

    a_r10_startup_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(engine_run) |-> (on_cnt == OW'(STARTUP_CYC)));

    a_r12_pop_single: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_pop |=> !rxq_pop);

endmodule

bind spi_uart_ctrl ucs_chk #(.STARTUP_CYC(STARTUP_CYC)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .osc_en        (osc_en),
    .engine_run    (engine_run),
    .hw_shdn       (hw_shdn),
    .tx_idle       (tx_idle),
    .tx_hold_valid (tx_hold_valid),
    .tx_hold_data  (tx_hold_data),
    .rxq_clear     (rxq_clear),
    .rxq_pop       (rxq_pop),
    .irq           (irq),
    .rts_out       (rts_out),
    .frame_done    (frame_done)
);

// File: tb/spi_uart_ctrl_tb.sv
module spi_uart_ctrl_tb;

    localparam int STARTUP = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic hw_shdn = 1'b0, cts_in = 1'b0;
    logic rts_out, irq, osc_en, engine_run;
    logic tx_hold_valid, tx_hold_par, tx_two_stop;
    logic [7:0] tx_hold_data;
    logic tx_take = 1'b0, tx_idle = 1'b1;
    logic rxq_valid = 1'b0, rxq_par = 1'b0;
    logic [7:0] rxq_data = 8'd0;
    logic rxq_pop, rxq_clear;
    logic rx_frame_err = 1'b0, rx_frame_ok = 1'b0, rx_line_edge = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int pop_cnt = 0;
    int on_len = 0;
    int wake_len = -1;
    logic er_prev = 1'b1;
    logic osc_low_seen = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spi_uart_ctrl #(.STARTUP_CYC(STARTUP), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
        .hw_shdn(hw_shdn), .cts_in(cts_in), .rts_out(rts_out), .irq(irq),
        .osc_en(osc_en), .engine_run(engine_run),
        .tx_hold_valid(tx_hold_valid), .tx_hold_data(tx_hold_data),
        .tx_hold_par(tx_hold_par), .tx_two_stop(tx_two_stop),
        .tx_take(tx_take), .tx_idle(tx_idle),
        .rxq_valid(rxq_valid), .rxq_data(rxq_data), .rxq_par(rxq_par),
        .rxq_pop(rxq_pop), .rxq_clear(rxq_clear),
        .rx_frame_err(rx_frame_err), .rx_frame_ok(rx_frame_ok),
        .rx_line_edge(rx_line_edge)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rxq_pop) pop_cnt++;
            if (!osc_en) begin
                on_len = 0;
                osc_low_seen = 1'b1;
            end else if (!engine_run) begin
                on_len++;
            end
            if (engine_run && !er_prev) wake_len = on_len;
            er_prev = engine_run;
        end
    end

    function automatic logic [15:0] exp_cfg(input logic r, t, sd, tm, st, fe, cts);
        return {r, t, sd, tm, st, fe, cts, 9'd0};
    endfunction

    function automatic logic [15:0] exp_data(input logic r, t, fe, cts, par,
                                             input logic [7:0] d);
        return {r, t, 3'd0, fe, cts, par, d};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [15:0] cmd, input int nbits, output logic [15:0] resp);
        resp = '0;
        @(negedge clk);
        cs_n = 1'b0;
        wait_cyc(6);
        for (int i = 0; i < nbits; i++) begin
            mosi = cmd[15-i];
            resp[15-i] = miso;
            wait_cyc(4);
            sclk = 1'b1;
            wait_cyc(4);
            sclk = 1'b0;
        end
        wait_cyc(4);
        cs_n = 1'b1;
        wait_cyc(8);
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
        wait_cyc(2);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
            finish_run();
        end
    end

    initial begin
        logic [15:0] resp;
        logic [15:0] cmd;
        int unused_seed;
        int pops0;
        logic v, p, rb, is_wr;
        logic [7:0] d;

        unused_seed = $urandom(32'd7321);
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);

        // R9 reset state
        check("R9 osc_en", {15'd0, osc_en}, 16'd1);
        check("R9 engine_run", {15'd0, engine_run}, 16'd1);
        check("R9 irq", {15'd0, irq}, 16'd0);
        check("R9 rts", {15'd0, rts_out}, 16'd0);
        check("R9 hold_valid", {15'd0, tx_hold_valid}, 16'd0);
        xfer(16'h4000, 16, resp);
        check("R9 R2 cfg read", resp, exp_cfg(0, 1, 0, 0, 0, 0, 0));

        cts_in = 1'b1;
        xfer(16'h0000, 16, resp);
        check("R5 R2 cts in data read", resp, exp_data(0, 1, 0, 1, 0, 8'h00));

        // R1 R8 configuration write
        xfer(16'hD800, 16, resp);
        check("R2 cfg-write response", resp, exp_cfg(0, 1, 0, 0, 0, 0, 1));
        check("R1 two stop", {15'd0, tx_two_stop}, 16'd1);
        check("R8 irq mask and T", {15'd0, irq}, 16'd1);

        // R13 load holding buffer
        xfer(16'h83A5, 16, resp);
        check("R2 data-write response", resp, exp_data(0, 1, 0, 1, 0, 8'h00));
        check("R13 hold", {6'd0, tx_hold_valid, tx_hold_par, tx_hold_data}, {6'd0, 2'b11, 8'hA5});
        check("R8 irq off when T=0", {15'd0, irq}, 16'd0);
        check("R5 rts written", {15'd0, rts_out}, 16'd1);

        // R1 short frame ignored
        xfer(16'h8000, 8, resp);
        check("R1 short frame rts", {15'd0, rts_out}, 16'd1);
        check("R1 short frame hold", {8'd0, tx_hold_data}, 16'h00A5);

        pulse(tx_take);
        check("R13 take sets T", {15'd0, tx_hold_valid}, 16'd0);
        check("R8 irq back", {15'd0, irq}, 16'd1);

        xfer(16'h843C, 16, resp);
        check("R13 TE=1 no load", {7'd0, tx_hold_valid, tx_hold_data}, {7'd0, 1'b0, 8'hA5});
        check("R5 rts cleared", {15'd0, rts_out}, 16'd0);

        // R12 R2 random data transfers
        for (int k = 0; k < 24; k++) begin
            v = 1'($urandom % 2);
            d = 8'($urandom);
            p = 1'($urandom % 2);
            rb = 1'($urandom % 2);
            is_wr = 1'($urandom % 2);
            rxq_valid = v;
            rxq_data = d;
            rxq_par = p;
            cmd = is_wr ? {6'b100001, rb, 1'b0, d} : 16'h0000;
            pops0 = pop_cnt;
            xfer(cmd, 16, resp);
            check("R2 random data response", resp,
                  exp_data(v, 1, 0, 1, v ? p : 1'b0, v ? d : 8'h00));
            check("R12 pop count", 16'(pop_cnt - pops0), {15'd0, v});
            if (is_wr) check("R5 random rts", {15'd0, rts_out}, {15'd0, rb});
            rxq_valid = 1'b0;
        end

        // R12 config read does not pop
        rxq_valid = 1'b1;
        pops0 = pop_cnt;
        xfer(16'h4000, 16, resp);
        check("R12 cfg read no pop", 16'(pop_cnt - pops0), 16'd0);
        rxq_valid = 1'b0;

        // R11 framing error flag
        pulse(rx_frame_err);
        xfer(16'h0000, 16, resp);
        check("R11 fe set", {15'd0, resp[10]}, 16'd1);
        xfer(16'h0000, 16, resp);
        check("R11 read keeps fe", {15'd0, resp[10]}, 16'd1);
        pulse(rx_frame_ok);
        xfer(16'h0000, 16, resp);
        check("R11 fe cleared by good frame", {15'd0, resp[10]}, 16'd0);
        pulse(rx_frame_err);
        xfer(16'hD800, 16, resp);
        check("R11 fe visible before cfg write", {15'd0, resp[10]}, 16'd1);
        xfer(16'h0000, 16, resp);
        check("R11 cfg write clears fe", {15'd0, resp[10]}, 16'd0);

        // R3 R6 software shutdown with drain
        cts_in = 1'b0;
        xfer(16'h825A, 16, resp);
        tx_idle = 1'b0;
        xfer(16'hF800, 16, resp);
        check("R3 osc held while T=0", {15'd0, osc_en}, 16'd1);
        xfer(16'h4000, 16, resp);
        check("R6 draining readback", resp, exp_cfg(0, 0, 0, 1, 1, 0, 0));
        pulse(tx_take);
        xfer(16'h4000, 16, resp);
        check("R6 T set but tx busy", resp, exp_cfg(0, 1, 0, 1, 1, 0, 0));
        check("R3 osc held while tx busy", {15'd0, osc_en}, 16'd1);
        @(negedge clk);
        tx_idle = 1'b1;
        wait_cyc(3);
        check("R3 osc off after idle", {15'd0, osc_en}, 16'd0);
        check("R4 cleared", {5'd0, rxq_clear, engine_run, tx_hold_par, tx_hold_data},
              {5'd0, 1'b1, 1'b0, 1'b0, 8'h00});
        check("R8 irq low in shutdown", {15'd0, irq}, 16'd0);
        rxq_valid = 1'b1;
        rxq_data = 8'hFF;
        pops0 = pop_cnt;
        xfer(16'h4000, 16, resp);
        check("R6 R4 off readback", resp, exp_cfg(0, 0, 1, 1, 1, 0, 0));
        xfer(16'h0000, 16, resp);
        check("R4 R reads 0 in shutdown", resp, exp_data(0, 0, 0, 0, 0, 8'h00));
        check("R12 no pop in shutdown", 16'(pop_cnt - pops0), 16'd0);
        rxq_valid = 1'b0;

        // R5 R11 R13 while shut down
        xfer(16'h8277, 16, resp);
        check("R5 rts in shutdown", {15'd0, rts_out}, 16'd1);
        check("R13 no load in shutdown", {7'd0, tx_hold_valid, tx_hold_data}, 16'd0);
        cts_in = 1'b1;
        pulse(rx_line_edge);
        xfer(16'h0000, 16, resp);
        check("R11 R5 activity and cts in shutdown", resp, exp_data(0, 0, 1, 1, 0, 8'h00));

        // R10 wake
        wake_len = -1;
        xfer(16'hD800, 16, resp);
        wait_cyc(STARTUP + 10);
        check("R10 wake length", 16'(wake_len), 16'(STARTUP));
        check("R10 T after wake", {14'd0, engine_run, irq}, 16'd3);
        check("R5 rts kept through wake", {15'd0, rts_out}, 16'd1);
        xfer(16'h0000, 16, resp);
        check("R10 R11 data read after wake", resp, exp_data(0, 1, 0, 1, 0, 8'h00));

        // R7 hardware shutdown with transmit busy
        xfer(16'h8011, 16, resp);
        tx_idle = 1'b0;
        @(negedge clk);
        hw_shdn = 1'b1;
        @(negedge clk);
        check("R7 osc off next cycle", {15'd0, osc_en}, 16'd0);
        xfer(16'h4000, 16, resp);
        check("R7 readback", resp, exp_cfg(0, 0, 1, 1, 1, 0, 1));
        wake_len = -1;
        @(negedge clk);
        hw_shdn = 1'b0;
        tx_idle = 1'b1;
        wait_cyc(STARTUP + 10);
        check("R7 R10 wake after release", 16'(wake_len), 16'(STARTUP));

        // R3 cancelled drain
        xfer(16'h8012, 16, resp);
        tx_idle = 1'b0;
        osc_low_seen = 1'b0;
        xfer(16'hF800, 16, resp);
        xfer(16'hD800, 16, resp);
        pulse(tx_take);
        tx_idle = 1'b1;
        wait_cyc(20);
        check("R3 cancel keeps osc", {15'd0, osc_low_seen}, 16'd0);
        xfer(16'h4000, 16, resp);
        check("R3 cancel readback", resp, exp_cfg(0, 1, 0, 1, 1, 0, 1));

        done = 1'b1;
        finish_run();
    end

endmodule